// File: doc/BRIEF.md
# Parking Lot Occupancy Controller

This block is a synchronous controller for a small car park. It watches an entry sensor and an exit sensor and keeps count of the parked cars. From that count it reports the number of free spaces. It lights a "lot full" lamp when every space is taken. It opens the door for each car it admits or releases, and holds the door open for a fixed number of pulses of an external timing tick.

Each sensor is edge-detected, so a car that keeps a sensor asserted counts as a single event. A five-state sequencer serves each event. When it sees a valid event it enters a checking state. A checked entry that finds a free space raises the count and opens the door. A checked exit lowers the count and opens the door. When the door closes, the sequencer goes back to waiting. If the lot is full it instead goes to a dedicated full state, where entry requests are refused and exits are still served. Clock division, display decoding and sensor debouncing are left to neighbouring blocks.

Top module: `lot_occupancy_ctrl`

## Requirements
- R1: After a synchronous reset, `occupied` is 0, `freeSpaces` equals SPACES (default 4), and `fullLamp`, `doorLamp` and `doorEnable` are all 0.
- R2: `freeSpaces` always equals SPACES minus `occupied`, and `occupied` never exceeds SPACES.
- R3: A rising edge on `entrySense` while waiting, with a space free, raises `occupied` by one and lights `doorLamp`, both visible two clock edges after the edge is sampled.
- R4: A rising edge on `exitSense` while waiting or full, with at least one car parked, lowers `occupied` by one and lights `doorLamp`, both visible two clock edges after the edge is sampled.
- R5: `fullLamp` is 1 exactly when `occupied` equals SPACES. While the lot is full, entry edges leave `occupied` unchanged and do not open the door.
- R6: `doorLamp` stays lit until DOOR_TICKS (default 2) cycles with `doorTick` high have been seen in the open state. It goes dark on the clock edge that samples the last of those ticks.
- R7: `doorEnable` is high for exactly one cycle, the first cycle in which `doorLamp` is lit.
- R8: An exit edge with `occupied` equal to 0 is ignored: the count stays 0 and the door stays closed.
- R9: If entry and exit edges arrive in the same waiting cycle with cars parked, the exit is served and the entry event is dropped.
- R10: A sensor held high for many cycles produces only one event.
- R11: Sensor edges that arrive while the door is open are ignored. `occupied` is unchanged after the door closes, and the door does not reopen for them.
- R12: After the door closes on a full lot, a later exit edge is still accepted and brings `fullLamp` back to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| entrySense | input | 1 | Entry sensor; a rising edge requests admission |
| exitSense | input | 1 | Exit sensor; a rising edge requests release |
| doorTick | input | 1 | Timing pulse that counts down the door-open time |
| occupied | output | $clog2(SPACES+1) | Number of parked cars |
| freeSpaces | output | $clog2(SPACES+1) | Number of free spaces |
| fullLamp | output | 1 | Lit when every space is taken |
| doorLamp | output | 1 | Lit while the door is held open |
| doorEnable | output | 1 | One-cycle command that opens the door |

## Verification
Two pairs of functions can land in the same cycle. The first pair is an entry edge and an exit edge, both seen on one waiting cycle. The bench asserts both sensors on the same falling clock edge, then checks that the count went down by one and that, after the door closed, the dropped entry left no trace. The second pair is a fresh sensor edge and the door-open interval. The bench pulses both sensors between timing ticks and then closes the door. It checks that the count did not move and that the door stayed shut afterwards.

// File: rtl/lot_pkg.sv
package lot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK_IN,
    ST_CHK_OUT,
    ST_FULL,
    ST_DOOR
  } lotState_t;

  typedef struct packed {
    logic incOcc;
    logic decOcc;
    logic tickAdv;
    logic tickClr;
  } lotStrobe_t;

endpackage

// File: rtl/lot_edge.sv
module lot_edge (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic levelQ;

  always_ff @(posedge clk) begin
    if (rst) levelQ <= 1'b0;
    else     levelQ <= level;
  end

  assign rise = level & ~levelQ;
endmodule

// File: rtl/lot_datapath.sv
module lot_datapath
  import lot_pkg::*;
#(
  parameter int SPACES     = 4,
  parameter int DOOR_TICKS = 2,
  localparam int CNT_W     = $clog2(SPACES + 1),
  localparam int TICK_W    = $clog2(DOOR_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             entrySense,
  input  logic             exitSense,
  input  lotStrobe_t       strobe,
  output logic             entryEvt,
  output logic             exitEvt,
  output logic             atFull,
  output logic             isEmpty,
  output logic             tickLast,
  output logic [CNT_W-1:0] occCount,
  output logic [CNT_W-1:0] freeCount
);
  localparam logic [CNT_W-1:0]  CAP      = CNT_W'(SPACES);
  localparam logic [TICK_W-1:0] TICK_END = TICK_W'(DOOR_TICKS - 1);

  logic [CNT_W-1:0]  occQ;
  logic [TICK_W-1:0] tickQ;

  lot_edge entryEdge_i (.clk(clk), .rst(rst), .level(entrySense), .rise(entryEvt));
  lot_edge exitEdge_i  (.clk(clk), .rst(rst), .level(exitSense),  .rise(exitEvt));

  always_ff @(posedge clk) begin
    if (rst) begin
      occQ <= '0;
    end else if (strobe.incOcc && occQ != CAP) begin
      occQ <= occQ + 1'b1;
    end else if (strobe.decOcc && occQ != '0) begin
      occQ <= occQ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.tickClr) begin
      tickQ <= '0;
    end else if (strobe.tickAdv) begin
      tickQ <= tickLast ? '0 : tickQ + 1'b1;
    end
  end

  assign tickLast  = (tickQ == TICK_END);
  assign atFull    = (occQ == CAP);
  assign isEmpty   = (occQ == '0);
  assign occCount  = occQ;
  assign freeCount = CAP - occQ;
endmodule

// File: rtl/lot_control.sv
module lot_control
  import lot_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       entryEvt,
  input  logic       exitEvt,
  input  logic       atFull,
  input  logic       isEmpty,
  input  logic       tickLast,
  input  logic       doorTick,
  output lotStrobe_t strobe,
  output logic       doorLamp,
  output logic       doorEnable
);
  lotState_t stateQ, stateD;
  logic      kickQ;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (exitEvt && !isEmpty) stateD = ST_CHK_OUT;
        else if (entryEvt)       stateD = ST_CHK_IN;
      end
      ST_FULL: begin
        if (exitEvt) stateD = ST_CHK_OUT;
      end
      ST_CHK_IN: begin
        strobe.tickClr = 1'b1;
        if (!atFull) begin
          strobe.incOcc = 1'b1;
          stateD        = ST_DOOR;
        end else begin
          stateD = ST_FULL;
        end
      end
      ST_CHK_OUT: begin
        strobe.tickClr = 1'b1;
        strobe.decOcc  = 1'b1;
        stateD         = ST_DOOR;
      end
      ST_DOOR: begin
        if (doorTick) begin
          strobe.tickAdv = 1'b1;
          if (tickLast) stateD = atFull ? ST_FULL : ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      kickQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      kickQ  <= (stateD == ST_DOOR) && (stateQ != ST_DOOR);
    end
  end

  assign doorLamp   = (stateQ == ST_DOOR);
  assign doorEnable = kickQ;
endmodule

// File: rtl/lot_occupancy_ctrl.sv
module lot_occupancy_ctrl
  import lot_pkg::*;
#(
  parameter int SPACES     = 4,
  parameter int DOOR_TICKS = 2,
  localparam int CNT_W     = $clog2(SPACES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             entrySense,
  input  logic             exitSense,
  input  logic             doorTick,
  output logic [CNT_W-1:0] occupied,
  output logic [CNT_W-1:0] freeSpaces,
  output logic             fullLamp,
  output logic             doorLamp,
  output logic             doorEnable
);
  lotStrobe_t strobe;
  logic entryEvt, exitEvt, atFull, isEmpty, tickLast;

  lot_datapath #(.SPACES(SPACES), .DOOR_TICKS(DOOR_TICKS)) datapath_i (
    .clk(clk), .rst(rst), .entrySense(entrySense), .exitSense(exitSense),
    .strobe(strobe), .entryEvt(entryEvt), .exitEvt(exitEvt), .atFull(atFull),
    .isEmpty(isEmpty), .tickLast(tickLast), .occCount(occupied), .freeCount(freeSpaces)
  );

  lot_control control_i (
    .clk(clk), .rst(rst), .entryEvt(entryEvt), .exitEvt(exitEvt), .atFull(atFull),
    .isEmpty(isEmpty), .tickLast(tickLast), .doorTick(doorTick), .strobe(strobe),
    .doorLamp(doorLamp), .doorEnable(doorEnable)
  );

  assign fullLamp = atFull;
endmodule

// File: rtl/lot_occupancy_chk.sv
module lot_occupancy_chk #(
  parameter int SPACES = 4,
  localparam int CNT_W = $clog2(SPACES + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             doorTick,
  input logic [CNT_W-1:0] occupied,
  input logic [CNT_W-1:0] freeSpaces,
  input logic             fullLamp,
  input logic             doorLamp,
  input logic             doorEnable
);
  // R2: the count stays within the lot size
  assert_occ_bound_R2: assert property (@(posedge clk) disable iff (rst)
    occupied <= CNT_W'(SPACES));

  // R2: outputs from both halves agree on capacity
  assert_free_sum_R2: assert property (@(posedge clk) disable iff (rst)
    (occupied + freeSpaces) == CNT_W'(SPACES));

  // R3/R4: the count moves by one step only, and only while the door opens
  assert_occ_step_R3: assert property (@(posedge clk) disable iff (rst)
    (occupied != $past(occupied)) |->
      (doorLamp && (occupied == $past(occupied) + 1'b1 || occupied == $past(occupied) - 1'b1)));

  // R7: the open command coincides with the first lit cycle
  assert_kick_in_door_R7: assert property (@(posedge clk) disable iff (rst)
    doorEnable |-> doorLamp);
  assert_kick_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(doorLamp) |-> doorEnable);
  assert_kick_single_R7: assert property (@(posedge clk) disable iff (rst)
    doorEnable |=> !doorEnable);

  // R6: the door only closes after a timing tick
  assert_close_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(doorLamp) |-> $past(doorTick));
endmodule

bind lot_occupancy_ctrl lot_occupancy_chk #(.SPACES(SPACES)) chk_i (
  .clk(clk), .rst(rst), .doorTick(doorTick), .occupied(occupied),
  .freeSpaces(freeSpaces), .fullLamp(fullLamp), .doorLamp(doorLamp),
  .doorEnable(doorEnable)
);

// File: tb/lot_occupancy_ctrl_tb.sv
`timescale 1ns/1ps
module lot_occupancy_ctrl_tb_top;
  localparam int SPACES     = 4;
  localparam int DOOR_TICKS = 2;
  localparam int CNT_W      = $clog2(SPACES + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic entrySense = 1'b0, exitSense = 1'b0, doorTick = 1'b0;
  logic [CNT_W-1:0] occupied, freeSpaces;
  logic fullLamp, doorLamp, doorEnable;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  lot_occupancy_ctrl #(.SPACES(SPACES), .DOOR_TICKS(DOOR_TICKS)) dut_i (
    .clk(clk), .rst(rst), .entrySense(entrySense), .exitSense(exitSense),
    .doorTick(doorTick), .occupied(occupied), .freeSpaces(freeSpaces),
    .fullLamp(fullLamp), .doorLamp(doorLamp), .doorEnable(doorEnable)
  );

  // vector: {entry, exit, expected occupied[2:0], expected doorLamp}
  localparam int NVEC = 10;
  localparam logic [5:0] VEC [NVEC] = '{
    {2'b10, 3'd1, 1'b1}, {2'b10, 3'd2, 1'b1}, {2'b10, 3'd3, 1'b1},
    {2'b10, 3'd4, 1'b1}, {2'b10, 3'd4, 1'b0}, {2'b01, 3'd3, 1'b1},
    {2'b10, 3'd4, 1'b1}, {2'b01, 3'd3, 1'b1}, {2'b01, 3'd2, 1'b1},
    {2'b01, 3'd1, 1'b1}
  };

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(bit ent, bit ext);
    @(negedge clk); entrySense = ent; exitSense = ext;
    @(negedge clk); entrySense = 1'b0; exitSense = 1'b0;
    @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); doorTick = 1'b1;
    @(negedge clk); doorTick = 1'b0;
  endtask

  task automatic closeDoor();
    for (int i = 0; i < DOOR_TICKS; i++) tick();
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    doReset();
    // R1 / R2 reset state
    check("R1 occupied", occupied, 0);
    check("R2 free", freeSpaces, SPACES);
    check("R1 lamps", {fullLamp, doorLamp, doorEnable}, 0);

    // table walk: R3 R4 R5 R12
    for (int v = 0; v < NVEC; v++) begin
      pulse(VEC[v][5], VEC[v][4]);
      check(VEC[v][5] ? "R3 entry count" : "R4 exit count", occupied, VEC[v][3:1]);
      check("R5 door/full state", doorLamp, VEC[v][0]);
      check("R2 free", freeSpaces, SPACES - VEC[v][3:1]);
      check("R5 full lamp", fullLamp, VEC[v][3:1] == SPACES);
      closeDoor();
      check("R6 door closed", doorLamp, 0);
    end

    // R8 exit on empty lot
    doReset();
    pulse(1'b0, 1'b1);
    check("R8 count", occupied, 0);
    check("R8 door", doorLamp, 0);

    // R10 held sensor, R7 open pulse, R6 tick count
    @(negedge clk); entrySense = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R7 enable first cycle", doorEnable, 1);
    check("R3 held entry count", occupied, 1);
    @(negedge clk);
    check("R7 enable drops", doorEnable, 0);
    check("R7 lamp stays", doorLamp, 1);
    tick();
    check("R6 still open after one tick", doorLamp, 1);
    tick();
    check("R6 closed after last tick", doorLamp, 0);
    repeat (5) @(negedge clk);
    check("R10 held sensor one event", occupied, 1);
    entrySense = 1'b0;
    @(negedge clk);

    // R11 events during door open
    pulse(1'b1, 1'b0);
    check("R3 count", occupied, 2);
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    closeDoor();
    repeat (3) @(negedge clk);
    check("R11 count unchanged", occupied, 2);
    check("R11 door stays shut", doorLamp, 0);

    // R9 simultaneous edges
    pulse(1'b1, 1'b1);
    check("R9 exit served", occupied, 1);
    closeDoor();
    repeat (3) @(negedge clk);
    check("R9 entry dropped", occupied, 1);
    check("R9 door shut", doorLamp, 0);

    // R12 exit from full lot
    for (int k = 0; k < 3; k++) begin pulse(1'b1, 1'b0); closeDoor(); end
    check("R5 full lamp", fullLamp, 1);
    check("R2 free zero", freeSpaces, 0);
    pulse(1'b0, 1'b1);
    check("R12 exit from full", occupied, 3);
    check("R12 full lamp off", fullLamp, 0);
    closeDoor();

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule